// File: doc/BRIEF.md
# Byte-Register SPI Master

This block is a serial peripheral interface master that software drives through six byte-wide registers. One register picks which of five devices get an active-low chip select. One register packs the serial clock divider and the transfer length. One register holds the mode flags. Writing the transmit-data register launches a transfer of 1 to 8 bits, and the bits received in that transfer land in the receive-data register. A status register tells software when the engine is idle, which is when the data registers may be touched again.

Several transfers can form one transaction. The engine keeps chip select asserted after a transfer unless that transfer ran with the end flag set, so longer device frames are built from successive byte writes. Clock polarity, clock phase and bit order are selectable. Half-duplex reception takes the input bits from the data-out line instead of the data-in line. An offline flag drops the drive enable of the pins so that the pad ring can float them.

Top module: `spi_byte_master`

## Requirements
- R1: Register map on `reg_addr`: 0 chip-select mask (bit i selects `cs_n_o[i]`), 1 divider/length, 2 mode flags, 3 transmit data (write only, reads 0), 4 receive data, 5 status. Registers 0 to 2 read back what was written (mode register bits 7:6 read 0). After reset every register reads 0 except status, which reads 0x20. After reset all chip selects are high and `pins_oe_o` is 1.
- R2: Divider/length byte: bits 4:0 hold a field f and bits 7:5 hold length−1. Each half period of the serial clock lasts 4f+1 fabric cycles, so a full bit period is 8f+2 cycles. A transfer moves length bits.
- R3: Mode byte: bit 0 offline, bit 1 end, bit 2 clock phase, bit 3 clock polarity, bit 4 half duplex, bit 5 LSB first.
- R4: A write to register 3 while idle starts a transfer. From the next cycle, `cs_n_o` equals the inverse of the chip-select mask and status bit 5 reads 0. Status bit 5 reads 1 again exactly (2·length+1)·(4f+1) cycles after the write edge, and chip select stays stable throughout the transfer.
- R5: When the end flag is 1, all chip selects go high when the transfer finishes. When it is 0, they stay as they were during the transfer.
- R6: `sclk_o` rests at the clock-polarity value. With phase 0, data is sampled on the leading edge of each bit and driven before it. With phase 1, data is driven on the leading edge and sampled on the trailing edge.
- R7: In MSB-first order the bits sent are bits length−1 down to 0 of the written byte. In LSB-first order they are bits 0 upward. The received bits are right-aligned in register 4, so a byte that a device sends in the same order reads back as that byte masked to length bits.
- R8: With half duplex set, received bits are taken from `mosi_i` and `miso_i` is ignored. Otherwise they come from `miso_i`.
- R9: With the offline flag set, `pins_oe_o` is 0 (sclk, data-out and chip selects undriven). With it clear, `pins_oe_o` is 1.
- R10: A write to register 3 during a transfer is ignored: the transfer in progress keeps its data, its settings and its duration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on address) |
| miso_i | input | 1 | Serial data from devices |
| mosi_i | input | 1 | Level seen on the data-out line (half-duplex input) |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to devices |
| cs_n_o | output | NUM_CS | Active-low chip selects |
| pins_oe_o | output | 1 | Drive enable for sclk, data-out and chip selects |

## Verification
The bench builds the block with its default of five chip selects and uses masks that light single and paired select lines. It sets divider fields 0, 1 and 2, which give half periods of 1, 5 and 9 cycles and let it check the finish cycle exactly. Combined with lengths of 1, 3, 5 and 8 bits, these settings cover all four clock polarity and phase pairs and both bit orders. They also bring a data write that lands inside a slow transfer, and the half-duplex path, within reach of a short run.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;
  localparam int BYTE_W      = 8;
  localparam int DIV_FIELD_W = 5;
  localparam int LEN_FIELD_W = 3;
  localparam int HALF_W      = DIV_FIELD_W + 2;
  localparam int BITS_W      = LEN_FIELD_W + 1;
  localparam int EDGE_W      = BITS_W + 1;

  localparam logic [2:0] ADDR_SEL    = 3'd0;
  localparam logic [2:0] ADDR_DIVLEN = 3'd1;
  localparam logic [2:0] ADDR_MODE   = 3'd2;
  localparam logic [2:0] ADDR_TXD    = 3'd3;
  localparam logic [2:0] ADDR_RXD    = 3'd4;
  localparam logic [2:0] ADDR_STAT   = 3'd5;
  localparam int STAT_IDLE_BIT = 5;

  // mode flags that the engine latches at start (mode byte bits 5:1)
  typedef struct packed {
    logic lsb_first;
    logic half_duplex;
    logic cpol;
    logic cpha;
    logic end_xfer;
  } xfer_mode_t;

  function automatic logic [HALF_W-1:0] half_period(input logic [DIV_FIELD_W-1:0] f);
    return {f, 2'b00} + HALF_W'(1);
  endfunction

  function automatic logic [BITS_W-1:0] xfer_bits(input logic [LEN_FIELD_W-1:0] c);
    return {1'b0, c} + BITS_W'(1);
  endfunction

  function automatic logic [BYTE_W-1:0] tx_preload(input logic [BYTE_W-1:0] d,
                                                   input logic [BITS_W-1:0] n,
                                                   input logic lsb);
    return lsb ? d : (d << (BITS_W'(BYTE_W) - n));
  endfunction

  function automatic logic [BYTE_W-1:0] rx_align(input logic [BYTE_W-1:0] r,
                                                 input logic [BITS_W-1:0] n,
                                                 input logic lsb);
    return lsb ? (r >> (BITS_W'(BYTE_W) - n)) : r;
  endfunction
endpackage

// File: rtl/spi_byte_regs.sv
module spi_byte_regs
  import spi_byte_pkg::*;
#(
  parameter int NUM_CS = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [2:0]          reg_addr,
  input  logic [BYTE_W-1:0]   reg_wdata,
  input  logic                busy,
  input  logic [BYTE_W-1:0]   rx_byte,
  output logic [NUM_CS-1:0]   sel_q,
  output logic [BYTE_W-1:0]   divlen_q,
  output logic [5:0]          mode_q,
  output logic                start_req,
  output logic [BYTE_W-1:0]   reg_rdata
);
  localparam int PAD_W = BYTE_W - NUM_CS;

  assign start_req = reg_wr && (reg_addr == ADDR_TXD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      divlen_q <= '0;
      mode_q   <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        ADDR_SEL:    sel_q    <= reg_wdata[NUM_CS-1:0];
        ADDR_DIVLEN: divlen_q <= reg_wdata;
        ADDR_MODE:   mode_q   <= reg_wdata[5:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_SEL:    reg_rdata = {{PAD_W{1'b0}}, sel_q};
      ADDR_DIVLEN: reg_rdata = divlen_q;
      ADDR_MODE:   reg_rdata = {2'b00, mode_q};
      ADDR_RXD:    reg_rdata = rx_byte;
      ADDR_STAT:   reg_rdata[STAT_IDLE_BIT] = !busy;
      default:     reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine
  import spi_byte_pkg::*;
#(
  parameter int NUM_CS = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_req,
  input  logic [BYTE_W-1:0]   tx_byte,
  input  logic [NUM_CS-1:0]   sel,
  input  logic [BYTE_W-1:0]   divlen,
  input  xfer_mode_t          mode_in,
  input  logic                idle_cpol,
  input  logic                miso_i,
  input  logic                mosi_i,
  output logic                busy,
  output logic                sclk,
  output logic                mosi,
  output logic [NUM_CS-1:0]   cs_active,
  output logic [BYTE_W-1:0]   rx_byte
);
  logic                busy_q, ph_q;
  logic [HALF_W-1:0]   half_q, half_lat;
  logic [BITS_W-1:0]   nbits_q;
  logic [EDGE_W-1:0]   edge_q;
  xfer_mode_t          mode_q;
  logic [BYTE_W-1:0]   tx_sr, rx_sr, rx_q;
  logic [NUM_CS-1:0]   cs_q;

  // named internal events
  logic [HALF_W-1:0] start_half;
  logic [BITS_W-1:0] start_bits;
  logic start_fire, tick, in_edges, edge_fire, finish, leading;
  logic sample_fire, shift_fire, in_bit;

  assign start_half  = half_period(divlen[DIV_FIELD_W-1:0]);
  assign start_bits  = xfer_bits(divlen[BYTE_W-1:DIV_FIELD_W]);
  assign start_fire  = start_req && !busy_q;
  assign tick        = busy_q && (half_q == '0);
  assign in_edges    = edge_q < {nbits_q, 1'b0};
  assign edge_fire   = tick && in_edges;
  assign finish      = tick && !in_edges;
  assign leading     = !edge_q[0];
  assign sample_fire = edge_fire && (mode_q.cpha ? !leading : leading);
  assign shift_fire  = edge_fire && (mode_q.cpha ? (leading && edge_q != '0) : !leading);
  assign in_bit      = mode_q.half_duplex ? mosi_i : miso_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      ph_q     <= 1'b0;
      half_q   <= '0;
      half_lat <= '0;
      nbits_q  <= '0;
      edge_q   <= '0;
      mode_q   <= '0;
      tx_sr    <= '0;
      rx_sr    <= '0;
      rx_q     <= '0;
      cs_q     <= '0;
    end else if (start_fire) begin
      busy_q   <= 1'b1;
      ph_q     <= 1'b0;
      half_lat <= start_half;
      half_q   <= start_half - HALF_W'(1);
      nbits_q  <= start_bits;
      edge_q   <= '0;
      mode_q   <= mode_in;
      tx_sr    <= tx_preload(tx_byte, start_bits, mode_in.lsb_first);
      rx_sr    <= '0;
      cs_q     <= sel;
    end else if (busy_q) begin
      half_q <= tick ? (half_lat - HALF_W'(1)) : (half_q - HALF_W'(1));
      if (edge_fire) begin
        ph_q   <= !ph_q;
        edge_q <= edge_q + EDGE_W'(1);
      end
      if (sample_fire)
        rx_sr <= mode_q.lsb_first ? {in_bit, rx_sr[BYTE_W-1:1]} : {rx_sr[BYTE_W-2:0], in_bit};
      if (shift_fire)
        tx_sr <= mode_q.lsb_first ? (tx_sr >> 1) : (tx_sr << 1);
      if (finish) begin
        busy_q <= 1'b0;
        rx_q   <= rx_align(rx_sr, nbits_q, mode_q.lsb_first);
        if (mode_q.end_xfer) cs_q <= '0;
      end
    end
  end

  assign busy      = busy_q;
  assign sclk      = ph_q ^ (busy_q ? mode_q.cpol : idle_cpol);
  assign mosi      = mode_q.lsb_first ? tx_sr[0] : tx_sr[BYTE_W-1];
  assign cs_active = cs_q;
  assign rx_byte   = rx_q;

  AST_EDGE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> edge_q <= {nbits_q, 1'b0}) else $error("edge count past length"); // R4
  AST_CS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && $past(busy_q) |-> $stable(cs_q)) else $error("chip select moved mid transfer"); // R4
  AST_SETTINGS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && $past(busy_q) |-> $stable(mode_q) && $stable(nbits_q) && $stable(half_lat))
    else $error("transfer settings changed while busy"); // R10
  AST_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) && mode_q.end_xfer |-> cs_q == '0) else $error("end flag kept select"); // R5
  AST_PHASE_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !ph_q) else $error("clock phase not home when idle"); // R6
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_byte_pkg::*;
#(
  parameter int NUM_CS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              miso_i,
  input  logic              mosi_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic              pins_oe_o
);
  logic [NUM_CS-1:0] sel_q, cs_active;
  logic [BYTE_W-1:0] divlen_q, rx_byte;
  logic [5:0]        mode_q;
  logic              start_req, busy;
  xfer_mode_t        mode_cur;

  assign mode_cur = xfer_mode_t'(mode_q[5:1]);

  spi_byte_regs #(.NUM_CS(NUM_CS)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy), .rx_byte(rx_byte),
    .sel_q(sel_q), .divlen_q(divlen_q), .mode_q(mode_q),
    .start_req(start_req), .reg_rdata(reg_rdata)
  );

  spi_byte_engine #(.NUM_CS(NUM_CS)) u_engine (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .tx_byte(reg_wdata),
    .sel(sel_q), .divlen(divlen_q), .mode_in(mode_cur), .idle_cpol(mode_cur.cpol),
    .miso_i(miso_i), .mosi_i(mosi_i), .busy(busy), .sclk(sclk_o), .mosi(mosi_o),
    .cs_active(cs_active), .rx_byte(rx_byte)
  );

  assign cs_n_o    = ~cs_active;
  assign pins_oe_o = !mode_q[0];

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk_o == mode_q[3]) else $error("idle clock level wrong"); // R6
endmodule

// File: tb/spi_byte_master_bench.sv
`timescale 1ns/1ps
module spi_byte_master_bench;
  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic miso_i, mosi_i, sclk_o, mosi_o, pins_oe_o;
  logic [4:0] cs_n_o;

  int n_checks = 0, n_fails = 0;
  bit done = 0;

  // bench-side device model state
  logic b_cpol = 0, b_cpha = 0, b_lsb = 0, b_hd = 0, b_active = 0;
  int   b_n = 8, s_idx = 0, cap_cnt = 0;
  logic [7:0] s_byte = 0, cap = 0;
  logic s_out = 0, prev_sclk = 0, prev_mosi = 0;

  assign miso_i = b_hd ? ~s_out : s_out;
  assign mosi_i = b_hd ? s_out : ~s_out;

  spi_byte_master u_spi_byte_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .miso_i(miso_i), .mosi_i(mosi_i),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .cs_n_o(cs_n_o), .pins_oe_o(pins_oe_o)
  );

  always #5 clk = ~clk;

  function automatic logic sbit(input int i);
    if (i >= b_n) return 1'b0;
    return b_lsb ? s_byte[i] : s_byte[b_n-1-i];
  endfunction

  always @(negedge clk) begin
    if (b_active && sclk_o != prev_sclk) begin
      logic lead;
      lead = (prev_sclk == b_cpol);
      if (b_cpha ? !lead : lead) begin
        if (b_lsb) cap[cap_cnt] = prev_mosi;
        else cap = {cap[6:0], prev_mosi};
        cap_cnt++;
      end
      if (b_cpha && lead) begin s_out = sbit(s_idx); s_idx++; end
      if (!b_cpha && !lead) begin s_idx++; s_out = sbit(s_idx); end
    end
    prev_sclk = sclk_o;
    prev_mosi = mosi_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic check_reset();
    logic [7:0] v;
    reg_read(0, v); chk(v == 0, "R1 sel reset", v, 0);
    reg_read(1, v); chk(v == 0, "R1 divlen reset", v, 0);
    reg_read(2, v); chk(v == 0, "R1 mode reset", v, 0);
    reg_read(4, v); chk(v == 0, "R1 rx reset", v, 0);
    reg_read(5, v); chk(v == 8'h20, "R1 status reset", v, 8'h20);
    chk(cs_n_o == 5'h1f, "R1 cs reset", cs_n_o, 5'h1f);
    chk(pins_oe_o == 1, "R1 drive enable reset", pins_oe_o, 1);
  endtask

  // one transfer; mode byte bits: 1 end, 2 cpha, 3 cpol, 4 half duplex, 5 lsb first
  task automatic run_xfer(input logic [7:0] tx, input logic [7:0] sb, input int n,
                          input int f, input logic [7:0] mode, input logic [4:0] sel,
                          input bit poke);
    logic [7:0] v, mask;
    int cycles, exp_cyc;
    mask = 8'((1 << n) - 1);
    exp_cyc = (2*n + 1) * (4*f + 1);
    reg_write(0, {3'b0, sel});
    reg_write(1, 8'((f & 31) | ((n - 1) << 5)));
    reg_write(2, mode);
    reg_read(1, v); chk(v == 8'((f & 31) | ((n - 1) << 5)), "R1 R2 divlen readback", v, (f & 31) | ((n - 1) << 5));
    reg_read(2, v); chk(v == mode, "R1 R3 mode readback", v, mode);
    chk(sclk_o == mode[3], "R6 idle clock level", sclk_o, mode[3]);
    b_cpha = mode[2]; b_cpol = mode[3]; b_hd = mode[4]; b_lsb = mode[5];
    b_n = n; s_byte = sb; s_idx = 0; cap = 0; cap_cnt = 0;
    s_out = b_cpha ? 1'b0 : sbit(0);
    b_active = 1;
    reg_write(3, tx);
    reg_addr = 5; #1;
    chk(reg_rdata[5] == 0, "R4 status busy after start", reg_rdata, 0);
    chk(cs_n_o == ~sel, "R4 chip select asserted", cs_n_o, ~sel);
    cycles = 0;
    while (!reg_rdata[5] && cycles < 10000) begin
      if (poke && cycles == 2) begin reg_wr = 1; reg_addr = 3; reg_wdata = ~tx; end
      @(negedge clk); reg_wr = 0; reg_addr = 5; #1; cycles++;
    end
    b_active = 0;
    chk(cycles == exp_cyc, poke ? "R10 R4 duration with busy write" : "R4 R2 transfer duration", cycles, exp_cyc);
    chk(cap_cnt == n, "R2 bit count", cap_cnt, n);
    chk((cap & mask) == (tx & mask), poke ? "R10 R7 sent data kept" : "R7 R6 sent data", cap & mask, tx & mask);
    reg_read(4, v);
    chk(v == (sb & mask), b_hd ? "R8 half-duplex receive" : "R7 R8 received data", v, sb & mask);
    if (mode[1]) chk(cs_n_o == 5'h1f, "R5 select released on end", cs_n_o, 5'h1f);
    else         chk(cs_n_o == ~sel, "R5 select held without end", cs_n_o, ~sel);
  endtask

  task automatic check_offline();
    reg_write(2, 8'h01);
    chk(pins_oe_o == 0, "R9 offline drops drive", pins_oe_o, 0);
    reg_write(2, 8'h00);
    chk(pins_oe_o == 1, "R9 online drives", pins_oe_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_reset();
    run_xfer(8'hA5, 8'h3C, 8, 0, 8'h00, 5'b00001, 0);  // mode 0, msb first, hold
    run_xfer(8'h5A, 8'hC3, 8, 0, 8'h02, 5'b00001, 0);  // same frame, end
    run_xfer(8'h13, 8'h1B, 5, 1, 8'h2E, 5'b00100, 0);  // cpol1 cpha1 lsb end
    run_xfer(8'h05, 8'h06, 3, 2, 8'h16, 5'b10000, 0);  // cpha1 half duplex end
    run_xfer(8'h01, 8'h01, 1, 0, 8'h2A, 5'b01010, 0);  // cpol1 cpha0 lsb one bit
    run_xfer(8'h96, 8'h69, 8, 1, 8'h02, 5'b00010, 1);  // busy write ignored
    check_offline();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule